// File: doc/BRIEF.md
# UART Byte Queue and Request Threshold Controller

This block holds the transmit and receive byte queues of a serial port and turns their fill levels into service requests. A serial shifter pushes received bytes, each with three error flags (parity, framing, break), and pops bytes to transmit. Software or a DMA engine does the other side. A single write-only control word sets four things: queue enable, DMA enable, a two-bit trigger code, and two self-clearing clear bits. A separate one-bit write sets multi-drop mode.

The trigger code selects a level of 1, 4, 8 or 14 bytes. The receive interrupt and the receive DMA request rise when the receive queue holds at least that many bytes. The transmit DMA request rises when the transmit queue holds that many bytes or fewer. When the queues are disabled, both directions shrink to one-byte holding buffers. Multi-drop mode forces only the receive side into that single-byte operation.

Top module: `uart_queue_ctrl`

## Requirements
- R1: Control word bits [5:4] hold the trigger code. Codes 0, 1, 2 and 3 select levels of 1, 4, 8 and 14 bytes. With queues in use, rx_irq is 1 exactly when the receive count is at least the selected level.
- R2: With queues in use, tx_dma_req is 1 exactly when the DMA enable bit (bit 3) is set and the transmit count is at most the selected level.
- R3: With bit 3 at 0, both rx_dma_req and tx_dma_req are 0. rx_irq does not depend on bit 3. With bit 3 at 1, rx_dma_req follows rx_irq.
- R4: With the queue enable bit (bit 0) at 0, each direction holds at most one byte and the trigger code is ignored. rx_irq is set at a count of 1 or more, and tx_dma_req (if enabled) is set only at a count of 0.
- R5: With multi-drop mode set and bit 0 at 1, the receive side holds at most one byte, while the transmit side keeps its full depth.
- R6: A control write with bit 0 at 1 and bit 1 at 1 empties the receive queue together with its stored error flags. The same write with bit 2 at 1 empties the transmit queue. A 0 in a clear bit changes nothing.
- R7: A clear bit written together with bit 0 at 0 has no effect on the queue contents.
- R8: A clear in the same cycle as a push to that queue wins, and the pushed byte is dropped.
- R9: A push to a queue already at its capacity is discarded, and the push sets that queue's overrun flag. The flag stays set until reset or until an effective clear of that queue. Counts never exceed the depth of 16.
- R10: A pop from an empty queue returns zero data and zero error flags and leaves the count at 0.
- R11: Bytes leave in arrival order, and each received byte comes out with the error flags pushed with it.
- R12: After reset, counts, flags, overruns and pop data are all 0. Counts change at the clock edge that takes the push or pop. The request outputs follow one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 6 | Control word: [0] queue enable, [1] receive clear, [2] transmit clear, [3] DMA enable, [5:4] trigger code |
| mdm_we | input | 1 | Multi-drop flag write strobe |
| mdm_wdata | input | 1 | Multi-drop flag value |
| tx_push | input | 1 | Push a byte into the transmit queue |
| tx_push_data | input | 8 | Byte to transmit |
| tx_pop | input | 1 | Pop a byte for the shifter |
| tx_pop_data | output | 8 | Popped transmit byte, registered |
| rx_push | input | 1 | Push a received byte |
| rx_push_data | input | 8 | Received byte |
| rx_push_err | input | 3 | Error flags of the received byte |
| rx_pop | input | 1 | Pop a received byte |
| rx_pop_data | output | 8 | Popped received byte, registered |
| rx_pop_err | output | 3 | Error flags of the popped byte |
| tx_count | output | 5 | Bytes held in the transmit queue |
| rx_count | output | 5 | Bytes held in the receive queue |
| tx_overrun | output | 1 | Sticky transmit overrun |
| rx_overrun | output | 1 | Sticky receive overrun |
| rx_irq | output | 1 | Receive data interrupt |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
A control write that clears a queue can land in the same cycle as a push into that queue. The bench provokes this by raising cfg_we with the clear bits together with both push strobes on one edge, after each queue has been partly filled. It judges the result by both counts reading 0 right after that edge, so the dropped bytes never appear. A property also requires a zero count on the cycle after every effective clear, whatever the push strobes did.

// File: rtl/uqc_pkg.sv
package uqc_pkg;
  localparam int CFG_W      = 6;
  localparam int CFG_QEN    = 0;
  localparam int CFG_RXCLR  = 1;
  localparam int CFG_TXCLR  = 2;
  localparam int CFG_DMAEN  = 3;
  localparam int CFG_TRIG_LO = 4;

  typedef enum logic [1:0] {
    TRIG_1  = 2'd0,
    TRIG_4  = 2'd1,
    TRIG_8  = 2'd2,
    TRIG_14 = 2'd3
  } trig_e;

  function automatic logic [4:0] trig_level(input trig_e code);
    case (code)
      TRIG_1:  trig_level = 5'd1;
      TRIG_4:  trig_level = 5'd4;
      TRIG_8:  trig_level = 5'd8;
      default: trig_level = 5'd14;
    endcase
  endfunction
endpackage

// File: rtl/uqc_fifo.sv
module uqc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          deep,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  pop_data,
  output logic [CW-1:0] count,
  output logic          overrun
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cap;
  logic          do_push, do_pop;

  assign cap     = deep ? CW'(DEPTH) : CW'(1);
  assign do_push = push & ~clr & (count < cap);
  assign do_pop  = pop & ~clr & (count != '0);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    bump = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst)         pop_data <= '0;
    else if (do_pop) pop_data <= mem[rptr];
    else if (pop)    pop_data <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr)                          overrun <= 1'b0;
    else if (push && !(count < cap))         overrun <= 1'b1;
  end
endmodule

// File: rtl/uqc_trigger.sv
module uqc_trigger
  import uqc_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  input  logic          rx_deep,
  input  logic          tx_deep,
  input  trig_e         trig,
  input  logic          dma_en,
  output logic          rx_irq,
  output logic          rx_dma_req,
  output logic          tx_dma_req
);
  logic [CW-1:0] level;
  logic          rx_hit, tx_hit;

  assign level  = CW'(trig_level(trig));
  assign rx_hit = rx_deep ? (rx_count >= level) : (rx_count != '0);
  assign tx_hit = tx_deep ? (tx_count <= level) : (tx_count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_irq     <= 1'b0;
      rx_dma_req <= 1'b0;
      tx_dma_req <= 1'b0;
    end else begin
      rx_irq     <= rx_hit;
      rx_dma_req <= rx_hit & dma_en;
      tx_dma_req <= tx_hit & dma_en;
    end
  end
endmodule

// File: rtl/uart_queue_ctrl.sv
module uart_queue_ctrl
  import uqc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 3,
  parameter int DEPTH  = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              mdm_we,
  input  logic              mdm_wdata,
  input  logic              tx_push,
  input  logic [DATA_W-1:0] tx_push_data,
  input  logic              tx_pop,
  output logic [DATA_W-1:0] tx_pop_data,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_push_data,
  input  logic [ERR_W-1:0]  rx_push_err,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_pop_data,
  output logic [ERR_W-1:0]  rx_pop_err,
  output logic [CW-1:0]     tx_count,
  output logic [CW-1:0]     rx_count,
  output logic              tx_overrun,
  output logic              rx_overrun,
  output logic              rx_irq,
  output logic              rx_dma_req,
  output logic              tx_dma_req
);
  logic  qen_q, dma_q, mdm_q;
  trig_e trig_q;
  logic  rx_clr, tx_clr, rx_deep;

  always_ff @(posedge clk) begin
    if (rst) begin
      qen_q  <= 1'b0;
      dma_q  <= 1'b0;
      trig_q <= TRIG_1;
      mdm_q  <= 1'b0;
    end else begin
      if (cfg_we) begin
        qen_q  <= cfg_wdata[CFG_QEN];
        dma_q  <= cfg_wdata[CFG_DMAEN];
        trig_q <= trig_e'(cfg_wdata[CFG_TRIG_LO +: 2]);
      end
      if (mdm_we) mdm_q <= mdm_wdata;
    end
  end

  assign rx_clr  = cfg_we & cfg_wdata[CFG_QEN] & cfg_wdata[CFG_RXCLR];
  assign tx_clr  = cfg_we & cfg_wdata[CFG_QEN] & cfg_wdata[CFG_TXCLR];
  assign rx_deep = qen_q & ~mdm_q;

  uqc_fifo #(.W(DATA_W), .DEPTH(DEPTH)) tx_q_i (
    .clk(clk), .rst(rst), .deep(qen_q), .clr(tx_clr),
    .push(tx_push), .push_data(tx_push_data),
    .pop(tx_pop), .pop_data(tx_pop_data),
    .count(tx_count), .overrun(tx_overrun)
  );

  uqc_fifo #(.W(DATA_W + ERR_W), .DEPTH(DEPTH)) rx_q_i (
    .clk(clk), .rst(rst), .deep(rx_deep), .clr(rx_clr),
    .push(rx_push), .push_data({rx_push_err, rx_push_data}),
    .pop(rx_pop), .pop_data({rx_pop_err, rx_pop_data}),
    .count(rx_count), .overrun(rx_overrun)
  );

  uqc_trigger #(.CW(CW)) trig_i (
    .clk(clk), .rst(rst),
    .rx_count(rx_count), .tx_count(tx_count),
    .rx_deep(rx_deep), .tx_deep(qen_q),
    .trig(trig_q), .dma_en(dma_q),
    .rx_irq(rx_irq), .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req)
  );
endmodule

// File: rtl/uqc_checker.sv
module uqc_checker #(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 3,
  parameter int DEPTH  = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [5:0]        cfg_wdata,
  input logic              rx_push,
  input logic              rx_pop,
  input logic [DATA_W-1:0] rx_pop_data,
  input logic [ERR_W-1:0]  rx_pop_err,
  input logic [CW-1:0]     tx_count,
  input logic [CW-1:0]     rx_count,
  input logic              tx_overrun,
  input logic              rx_dma_req,
  input logic              tx_dma_req
);
  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));

  // R8
  tx_clear_push_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we && cfg_wdata[0] && cfg_wdata[2] |=> tx_count == '0);

  // R6
  rx_clear_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we && cfg_wdata[0] && cfg_wdata[1] |=> rx_count == '0);

  // R3
  dma_gate_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we && !cfg_wdata[3] |-> ##2 (!tx_dma_req && !rx_dma_req));

  // R10
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    rx_pop && !rx_push && rx_count == '0 |=>
      (rx_pop_data == '0) && (rx_pop_err == '0) && (rx_count == '0));

  // R9
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    tx_overrun && !(cfg_we && cfg_wdata[0] && cfg_wdata[2]) |=> tx_overrun);
endmodule

bind uart_queue_ctrl uqc_checker #(.DATA_W(DATA_W), .ERR_W(ERR_W), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .rx_push(rx_push), .rx_pop(rx_pop), .rx_pop_data(rx_pop_data),
  .rx_pop_err(rx_pop_err), .tx_count(tx_count), .rx_count(rx_count),
  .tx_overrun(tx_overrun), .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req)
);

// File: tb/uart_queue_ctrl_tb_top.sv
`timescale 1ns/1ps
module uart_queue_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [5:0] cfg_wdata = '0;
  logic       mdm_we = 1'b0, mdm_wdata = 1'b0;
  logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic [7:0] tx_push_data = '0, rx_push_data = '0;
  logic [2:0] rx_push_err = '0;
  logic [7:0] tx_pop_data, rx_pop_data;
  logic [2:0] rx_pop_err;
  logic [4:0] tx_count, rx_count;
  logic       tx_overrun, rx_overrun, rx_irq, rx_dma_req, tx_dma_req;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  uart_queue_ctrl dut_i (.*);

  // {cfg[5:0], n_rx[4:0], n_tx[4:0], irq, rx_dma, tx_dma}
  localparam int NV = 11;
  localparam logic [18:0] VEC [NV] = '{
    {6'h09, 5'd1,  5'd1,  3'b111},   // R1 R2 level 1
    {6'h09, 5'd0,  5'd2,  3'b000},   // R1 R2 level 1, below/above
    {6'h19, 5'd3,  5'd4,  3'b001},   // R1 R2 level 4
    {6'h19, 5'd4,  5'd5,  3'b110},
    {6'h29, 5'd7,  5'd8,  3'b001},   // level 8
    {6'h29, 5'd8,  5'd9,  3'b110},
    {6'h39, 5'd13, 5'd14, 3'b001},   // level 14
    {6'h39, 5'd14, 5'd15, 3'b110},
    {6'h31, 5'd14, 5'd0,  3'b100},   // R3 DMA off
    {6'h38, 5'd1,  5'd0,  3'b111},   // R4 single-byte
    {6'h38, 5'd0,  5'd1,  3'b000}    // R4 single-byte
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic cfg_write(input logic [5:0] w);
    cfg_we = 1'b1; cfg_wdata = w; step(); cfg_we = 1'b0;
  endtask

  task automatic mdm_write(input logic v);
    mdm_we = 1'b1; mdm_wdata = v; step(); mdm_we = 1'b0;
  endtask

  task automatic push_both(input int nrx, input int ntx);
    for (int i = 0; i < ((nrx > ntx) ? nrx : ntx); i++) begin
      rx_push = (i < nrx); rx_push_data = 8'(i); rx_push_err = 3'(i);
      tx_push = (i < ntx); tx_push_data = 8'(i);
      step();
    end
    rx_push = 1'b0; tx_push = 1'b0;
  endtask

  task automatic rx_put(input logic [7:0] d, input logic [2:0] e);
    rx_push = 1'b1; rx_push_data = d; rx_push_err = e; step(); rx_push = 1'b0;
  endtask

  task automatic rx_get();
    rx_pop = 1'b1; step(); rx_pop = 1'b0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R12 reset state
    check("R12 tx_count", tx_count, 0);
    check("R12 rx_count", rx_count, 0);
    check("R12 flags", {rx_irq, rx_dma_req, tx_dma_req, tx_overrun, rx_overrun}, 0);
    check("R12 pop data", rx_pop_data, 0);

    // Table walk: thresholds, DMA gate, single-byte mode
    for (int v = 0; v < NV; v++) begin
      cfg_write(6'h07);
      cfg_write(VEC[v][18:13] | 6'h06);
      push_both(int'(VEC[v][12:8]), int'(VEC[v][7:3]));
      step();
      check($sformatf("R1 rx_irq vec%0d", v), rx_irq, VEC[v][2]);
      check($sformatf("R3 rx_dma vec%0d", v), rx_dma_req, VEC[v][1]);
      check($sformatf("R2 tx_dma vec%0d", v), tx_dma_req, VEC[v][0]);
      check($sformatf("R4 rx_count vec%0d", v), rx_count, int'(VEC[v][12:8]));
    end

    // R12 timing: count at the push edge, irq one edge later
    cfg_write(6'h07);
    cfg_write(6'h0F);
    step();
    rx_put(8'h11, 3'b000);
    check("R12 count at push edge", rx_count, 1);
    check("R12 irq not yet", rx_irq, 0);
    step();
    check("R12 irq next edge", rx_irq, 1);

    // R11 order with error flags
    cfg_write(6'h07);
    rx_put(8'hA1, 3'b001);
    rx_put(8'hB2, 3'b010);
    rx_put(8'hC3, 3'b100);
    rx_get(); check("R11 data0", rx_pop_data, 8'hA1); check("R11 err0", rx_pop_err, 3'b001);
    rx_get(); check("R11 data1", rx_pop_data, 8'hB2); check("R11 err1", rx_pop_err, 3'b010);
    rx_get(); check("R11 data2", rx_pop_data, 8'hC3); check("R11 err2", rx_pop_err, 3'b100);
    // R10 pop from empty
    rx_get();
    check("R10 empty data", rx_pop_data, 0);
    check("R10 empty err", rx_pop_err, 0);
    check("R10 empty count", rx_count, 0);

    // R6 receive clear drops stored errors too
    rx_put(8'hD4, 3'b111);
    rx_put(8'hE5, 3'b110);
    cfg_write(6'h03);
    check("R6 rx cleared", rx_count, 0);
    rx_put(8'hF6, 3'b000);
    rx_get();
    check("R6 new data", rx_pop_data, 8'hF6);
    check("R6 old err gone", rx_pop_err, 0);
    // R6 zero in clear bits does nothing
    push_both(0, 2);
    cfg_write(6'h01);
    check("R6 zero clear tx", tx_count, 2);
    // R7 clear with enable bit 0
    cfg_write(6'h04);
    check("R7 clear ignored", tx_count, 2);

    // R8 clear beats push in the same cycle
    cfg_write(6'h07);
    push_both(2, 3);
    cfg_we = 1'b1; cfg_wdata = 6'h07; tx_push = 1'b1; rx_push = 1'b1;
    step();
    cfg_we = 1'b0; tx_push = 1'b0; rx_push = 1'b0;
    check("R8 tx count", tx_count, 0);
    check("R8 rx count", rx_count, 0);

    // R9 overrun
    push_both(0, 17);
    check("R9 tx full", tx_count, 16);
    check("R9 tx overrun", tx_overrun, 1);
    check("R9 rx no overrun", rx_overrun, 0);
    step();
    check("R9 sticky", tx_overrun, 1);
    cfg_write(6'h07);
    check("R9 cleared", tx_overrun, 0);

    // R5 multi-drop
    mdm_write(1'b1);
    cfg_write(6'h07);
    push_both(2, 3);
    check("R5 rx single", rx_count, 1);
    check("R5 rx overrun", rx_overrun, 1);
    check("R5 tx deep", tx_count, 3);
    mdm_write(1'b0);

    // R4 queues disabled
    cfg_write(6'h07);
    cfg_write(6'h00);
    push_both(0, 2);
    check("R4 tx single", tx_count, 1);
    check("R4 tx overrun", tx_overrun, 1);

    report();
  end
endmodule